// File: doc/BRIEF.md
# Display Controller Register Window with Sprite-Table Copy Engine

This block is the register window of a tile-based display controller. It occupies ten consecutive byte locations of an I/O page and is addressed by a 4-bit index relative to the start of that window. A processor writes and reads these locations over a simple single-cycle register port. The block turns the control byte into individual mode outputs and base addresses. It holds the two scroll bytes and the line-compare byte. It also expands three palette bytes into per-color 8-bit gray levels for the pixel pipeline.

One location is a copy trigger. Writing a byte to it starts a 160-byte transfer from the 256-byte source page that the byte selects into sprite attribute memory. The block drives a read port toward system memory, which returns data combinationally in the same cycle. It drives a write port into sprite memory at the same time, and moves one byte per clock. A busy output tells the rest of the system that the transfer is running.

Top module: `lcd_io_regs`

## Requirements
- R1: After reset every register holds 0. As a result, the display, sprite and background enables and the tall-sprite select are 0, the tile base is 0x0800, the map base is 0x1800, every palette shade is 255, and no transfer is busy.
- R2: Control register index 0 drives the mode outputs: bit 7 turns the display on, bit 2 selects tall sprites, bit 1 enables sprites and bit 0 enables the background. Each output follows a write from the next cycle on.
- R3: Control bit 4 selects the tile data base: 0x0000 when the bit is set, 0x0800 when it is clear.
- R4: Control bit 3 selects the background map base: 0x1C00 when the bit is set, 0x1800 when it is clear.
- R5: Index 2 drives the vertical scroll output, index 3 the horizontal scroll output and index 5 the line-compare output. Each takes the written byte from the next cycle on.
- R6: Palette registers are at index 7 (background), index 8 (sprite set 0) and index 9 (sprite set 1). For color i, the field at bits [2i+1:2i] maps code 0, 1, 2 and 3 to the gray levels 255, 192, 96 and 0. That level appears on bits [8i+7:8i] of the matching shade output.
- R7: The read data output is combinational. For indexes 0 to 9 it returns the last byte written to that index, including indexes 1, 4 and 6. Indexes 10 to 15 read as 0, and writes to them change nothing.
- R8: A write of value V to index 6 starts a transfer. In each of the following 160 cycles, numbered i from 0 to 159, the block reads source address V*256+i and writes sprite-memory address 0xFE00+i with the byte the memory returns in that same cycle.
- R9: Busy goes high in the cycle after the trigger write and stays high for exactly 160 cycles. The memory read enable and the sprite write enable are high only while busy.
- R10: A write to index 6 while a transfer is busy restarts the copy at i = 0 with the new source page. It runs a further full 160 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index within the window |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| disp_on_o | output | 1 | Display enable |
| spr_tall_o | output | 1 | Tall sprite size select |
| spr_en_o | output | 1 | Sprite enable |
| bg_en_o | output | 1 | Background enable |
| tile_base_o | output | 16 | Tile data base address |
| map_base_o | output | 16 | Background map base address |
| scroll_y_o | output | 8 | Vertical scroll |
| scroll_x_o | output | 8 | Horizontal scroll |
| line_cmp_o | output | 8 | Line compare value |
| pal_bg_o | output | 32 | Background shades, four 8-bit levels |
| pal_spr0_o | output | 32 | Sprite set 0 shades |
| pal_spr1_o | output | 32 | Sprite set 1 shades |
| dma_busy_o | output | 1 | Copy in progress |
| mem_rd_en_o | output | 1 | System memory read enable |
| mem_rd_addr_o | output | 16 | System memory read address |
| mem_rd_data_i | input | 8 | System memory read data, same cycle |
| oam_we_o | output | 1 | Sprite memory write enable |
| oam_addr_o | output | 16 | Sprite memory write address |
| oam_wdata_o | output | 8 | Sprite memory write data |

## Verification
The control byte is driven with all-zero, all-one and mixed values such as 0x96 and 0x09. These show whether each mode output and each base-address select follows its own bit and no neighbouring bit. The palettes are loaded with patterns that put a different code in each field, such as 0xE4 and 0x1B, so that swapped fields or a wrong gray level show up on each color slot. Transfers run with several source pages against a memory whose data depends on both address bytes, so a wrong page, a skipped index or a late data path all change the written bytes. Busy is counted over an uninterrupted run, a trigger lands in the middle of a running copy, and register writes during a copy show that only index 6 disturbs the transfer.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned NUM_REGS  = 10;
  localparam int unsigned IDX_W     = 4;

  localparam logic [IDX_W-1:0] IX_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] IX_SCY  = 4'd2;
  localparam logic [IDX_W-1:0] IX_SCX  = 4'd3;
  localparam logic [IDX_W-1:0] IX_CMP  = 4'd5;
  localparam logic [IDX_W-1:0] IX_DMA  = 4'd6;
  localparam int unsigned      IX_PAL0 = 7;
  localparam int unsigned      PAL_CNT = 3;

  localparam int unsigned PAL_FIELDS = 4;
  localparam int unsigned PAL_CODE_W = 2;

  localparam logic [BYTE_W-1:0] SHADE_C0 = 8'd255;
  localparam logic [BYTE_W-1:0] SHADE_C1 = 8'd192;
  localparam logic [BYTE_W-1:0] SHADE_C2 = 8'd96;
  localparam logic [BYTE_W-1:0] SHADE_C3 = 8'd0;

  typedef struct packed {
    logic              disp_on;
    logic              spr_tall;
    logic              spr_en;
    logic              bg_en;
    logic [ADDR_W-1:0] tile_base;
    logic [ADDR_W-1:0] map_base;
  } lcd_mode_t;

  function automatic logic [BYTE_W-1:0] code_to_shade(input logic [PAL_CODE_W-1:0] code);
    case (code)
      2'd0:    return SHADE_C0;
      2'd1:    return SHADE_C1;
      2'd2:    return SHADE_C2;
      default: return SHADE_C3;
    endcase
  endfunction
endpackage

// File: rtl/lcd_ctrl_decode.sv
module lcd_ctrl_decode
  import lcd_regs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TILE_BASE_SET = 16'h0000,
  parameter logic [ADDR_W-1:0] TILE_BASE_CLR = 16'h0800,
  parameter logic [ADDR_W-1:0] MAP_BASE_SET  = 16'h1C00,
  parameter logic [ADDR_W-1:0] MAP_BASE_CLR  = 16'h1800
) (
  input  logic [BYTE_W-1:0] ctrl_i,
  output lcd_mode_t         mode_o
);
  localparam int unsigned B_ON   = 7;
  localparam int unsigned B_TILE = 4;
  localparam int unsigned B_MAP  = 3;
  localparam int unsigned B_TALL = 2;
  localparam int unsigned B_SPR  = 1;
  localparam int unsigned B_BG   = 0;

  always_comb begin
    mode_o.disp_on   = ctrl_i[B_ON];
    mode_o.spr_tall  = ctrl_i[B_TALL];
    mode_o.spr_en    = ctrl_i[B_SPR];
    mode_o.bg_en     = ctrl_i[B_BG];
    mode_o.tile_base = ctrl_i[B_TILE] ? TILE_BASE_SET : TILE_BASE_CLR;
    mode_o.map_base  = ctrl_i[B_MAP]  ? MAP_BASE_SET  : MAP_BASE_CLR;
  end
endmodule

// File: rtl/lcd_pal_expand.sv
module lcd_pal_expand
  import lcd_regs_pkg::*;
#(
  parameter int unsigned FIELDS = PAL_FIELDS,
  parameter int unsigned CODE_W = PAL_CODE_W,
  localparam int unsigned IN_W  = FIELDS * CODE_W,
  localparam int unsigned OUT_W = FIELDS * BYTE_W
) (
  input  logic [IN_W-1:0]  pal_i,
  output logic [OUT_W-1:0] shade_o
);
  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign shade_o[f*BYTE_W +: BYTE_W] = code_to_shade(pal_i[f*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/lcd_dma_engine.sv
module lcd_dma_engine #(
  parameter int unsigned          LEN    = 160,
  parameter int unsigned          AW     = 16,
  parameter int unsigned          DW     = 8,
  parameter int unsigned          OFS_W  = 8,
  parameter logic [AW-1:0]        DST_BASE = 16'hFE00,
  localparam int unsigned         PW     = AW - OFS_W,
  localparam int unsigned         CW     = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] page_i,
  output logic          busy_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] page_q;
  logic [AW-1:0] cnt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (start_i) begin
      // a trigger always wins, also mid-transfer
      busy_q <= 1'b1;
      cnt_q  <= '0;
      page_q <= page_i;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_ext   = {{(AW-CW){1'b0}}, cnt_q};
  assign busy_o    = busy_q;
  assign rd_en_o   = busy_q;
  assign rd_addr_o = {page_q, {OFS_W{1'b0}}} + cnt_ext;
  assign wr_en_o   = busy_q;
  assign wr_addr_o = DST_BASE + cnt_ext;
  assign wr_data_o = rd_data_i;
endmodule

// File: rtl/lcd_io_regs.sv
module lcd_io_regs
  import lcd_regs_pkg::*;
#(
  parameter int unsigned     DMA_LEN  = 160,
  parameter logic [15:0]     OAM_BASE = 16'hFE00,
  localparam int unsigned    SHADE_W  = PAL_FIELDS * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [IDX_W-1:0]   reg_addr_i,
  input  logic [BYTE_W-1:0]  reg_wdata_i,
  output logic [BYTE_W-1:0]  reg_rdata_o,
  output logic               disp_on_o,
  output logic               spr_tall_o,
  output logic               spr_en_o,
  output logic               bg_en_o,
  output logic [ADDR_W-1:0]  tile_base_o,
  output logic [ADDR_W-1:0]  map_base_o,
  output logic [BYTE_W-1:0]  scroll_y_o,
  output logic [BYTE_W-1:0]  scroll_x_o,
  output logic [BYTE_W-1:0]  line_cmp_o,
  output logic [SHADE_W-1:0] pal_bg_o,
  output logic [SHADE_W-1:0] pal_spr0_o,
  output logic [SHADE_W-1:0] pal_spr1_o,
  output logic               dma_busy_o,
  output logic               mem_rd_en_o,
  output logic [ADDR_W-1:0]  mem_rd_addr_o,
  input  logic [BYTE_W-1:0]  mem_rd_data_i,
  output logic               oam_we_o,
  output logic [ADDR_W-1:0]  oam_addr_o,
  output logic [BYTE_W-1:0]  oam_wdata_o
);
  logic [BYTE_W-1:0]  regs_q [NUM_REGS];
  logic [SHADE_W-1:0] shades [PAL_CNT];
  lcd_mode_t          mode;
  logic               dma_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= '0;
    end else if (reg_we_i) begin
      for (int k = 0; k < NUM_REGS; k++)
        if (reg_addr_i == IDX_W'(k)) regs_q[k] <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (reg_addr_i == IDX_W'(k)) reg_rdata_o = regs_q[k];
  end

  lcd_ctrl_decode u_dec (
    .ctrl_i (regs_q[IX_CTRL]),
    .mode_o (mode)
  );

  assign disp_on_o   = mode.disp_on;
  assign spr_tall_o  = mode.spr_tall;
  assign spr_en_o    = mode.spr_en;
  assign bg_en_o     = mode.bg_en;
  assign tile_base_o = mode.tile_base;
  assign map_base_o  = mode.map_base;
  assign scroll_y_o  = regs_q[IX_SCY];
  assign scroll_x_o  = regs_q[IX_SCX];
  assign line_cmp_o  = regs_q[IX_CMP];

  for (genvar p = 0; p < PAL_CNT; p++) begin : g_pal
    lcd_pal_expand u_pal (
      .pal_i   (regs_q[IX_PAL0 + p]),
      .shade_o (shades[p])
    );
  end

  assign pal_bg_o   = shades[0];
  assign pal_spr0_o = shades[1];
  assign pal_spr1_o = shades[2];

  assign dma_start = reg_we_i && (reg_addr_i == IX_DMA);

  lcd_dma_engine #(
    .LEN      (DMA_LEN),
    .AW       (ADDR_W),
    .DW       (BYTE_W),
    .OFS_W    (BYTE_W),
    .DST_BASE (OAM_BASE)
  ) u_dma (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dma_start),
    .page_i    (reg_wdata_i),
    .busy_o    (dma_busy_o),
    .rd_en_o   (mem_rd_en_o),
    .rd_addr_o (mem_rd_addr_o),
    .rd_data_i (mem_rd_data_i),
    .wr_en_o   (oam_we_o),
    .wr_addr_o (oam_addr_o),
    .wr_data_o (oam_wdata_o)
  );
endmodule

// File: rtl/lcd_io_regs_chk.sv
module lcd_io_regs_chk #(
  parameter int unsigned DMA_LEN  = 160,
  parameter logic [15:0] OAM_BASE = 16'hFE00
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [3:0]  reg_addr_i,
  input logic [7:0]  reg_wdata_i,
  input logic [7:0]  reg_rdata_o,
  input logic        disp_on_o,
  input logic [7:0]  scroll_y_o,
  input logic        dma_busy_o,
  input logic        mem_rd_en_o,
  input logic [15:0] mem_rd_addr_o,
  input logic        oam_we_o,
  input logic [15:0] oam_addr_o
);
  localparam logic [15:0] OAM_LAST = OAM_BASE + 16'(DMA_LEN - 1);
  logic trig;
  assign trig = reg_we_i && (reg_addr_i == 4'd6);

  AST_CTRL_ON_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd0) |=> (disp_on_o == $past(reg_wdata_i[7]))); // R2

  AST_SCROLL_Y_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd2) |=> (scroll_y_o == $past(reg_wdata_i))); // R5

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i < 4'd10)
      |=> (reg_addr_i != $past(reg_addr_i) || reg_rdata_o == $past(reg_wdata_i))); // R7

  AST_DMA_STARTS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (dma_busy_o && oam_addr_o == OAM_BASE
              && mem_rd_addr_o == {$past(reg_wdata_i), 8'h00})); // R10

  AST_DMA_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_busy_o && !trig && oam_addr_o != OAM_LAST)
      |=> (dma_busy_o && oam_addr_o == $past(oam_addr_o) + 16'd1)); // R8

  AST_DMA_SRC_TRACKS_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_busy_o |-> (mem_rd_addr_o[7:0] == oam_addr_o[7:0])); // R8

  AST_DMA_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_busy_o && !trig && oam_addr_o == OAM_LAST) |=> !dma_busy_o); // R9

  AST_NO_IDLE_TRAFFIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_busy_o |-> (!oam_we_o && !mem_rd_en_o)); // R9
endmodule

bind lcd_io_regs lcd_io_regs_chk #(
  .DMA_LEN  (DMA_LEN),
  .OAM_BASE (OAM_BASE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .disp_on_o     (disp_on_o),
  .scroll_y_o    (scroll_y_o),
  .dma_busy_o    (dma_busy_o),
  .mem_rd_en_o   (mem_rd_en_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .oam_we_o      (oam_we_o),
  .oam_addr_o    (oam_addr_o)
);

// File: tb/sim_lcd_io_regs.sv
`timescale 1ns/1ps
module sim_lcd_io_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic        disp_on, spr_tall, spr_en, bg_en;
  logic [15:0] tile_base, map_base;
  logic [7:0]  scy, scx, lcmp;
  logic [31:0] pbg, ps0, ps1;
  logic        busy, rd_en, oam_we;
  logic [15:0] rd_addr, oam_addr;
  logic [7:0]  rd_data, oam_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // memory contents depend on both address bytes
  assign rd_data = rd_addr[7:0] ^ {rd_addr[11:8], rd_addr[15:12]} ^ 8'h5A;

  lcd_io_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .disp_on_o(disp_on),
    .spr_tall_o(spr_tall), .spr_en_o(spr_en), .bg_en_o(bg_en),
    .tile_base_o(tile_base), .map_base_o(map_base), .scroll_y_o(scy),
    .scroll_x_o(scx), .line_cmp_o(lcmp), .pal_bg_o(pbg), .pal_spr0_o(ps0),
    .pal_spr1_o(ps1), .dma_busy_o(busy), .mem_rd_en_o(rd_en),
    .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data), .oam_we_o(oam_we),
    .oam_addr_o(oam_addr), .oam_wdata_o(oam_wdata)
  );

  // reference model state
  int m_reg [10];
  int m_busy = 0;
  int m_idx = 0;
  int m_page = 0;
  int busy_run = 0;

  function automatic int shade(input int code);
    case (code)
      0: return 255;
      1: return 192;
      2: return 96;
      default: return 0;
    endcase
  endfunction

  function automatic int pal_word(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) r = r | (shade((v >> (2*i)) & 3) << (8*i));
    return r;
  endfunction

  function automatic int mem_model(input int a);
    return (a & 255) ^ ((((a >> 8) & 15) << 4) | ((a >> 12) & 15)) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    if (we && addr < 10) m_reg[addr] = wdata;
    if (we && addr == 6) begin
      m_busy = 1; m_idx = 0; m_page = wdata;
    end else if (m_busy != 0) begin
      if (m_idx == 159) m_busy = 0;
      else m_idx++;
    end
  endtask

  task automatic compare_all();
    int c = m_reg[0];
    check("R2 disp_on", disp_on, (c >> 7) & 1);
    check("R2 spr_tall", spr_tall, (c >> 2) & 1);
    check("R2 spr_en", spr_en, (c >> 1) & 1);
    check("R2 bg_en", bg_en, c & 1);
    check("R3 tile_base", tile_base, ((c >> 4) & 1) ? 16'h0000 : 16'h0800);
    check("R4 map_base", map_base, ((c >> 3) & 1) ? 16'h1C00 : 16'h1800);
    check("R5 scroll_y", scy, m_reg[2]);
    check("R5 scroll_x", scx, m_reg[3]);
    check("R5 line_cmp", lcmp, m_reg[5]);
    check("R6 pal_bg", pbg, pal_word(m_reg[7]));
    check("R6 pal_spr0", ps0, pal_word(m_reg[8]));
    check("R6 pal_spr1", ps1, pal_word(m_reg[9]));
    check("R7 rdata", rdata, (addr < 10) ? m_reg[addr] : 0);
    check("R9 busy", busy, m_busy);
    check("R9 rd_en", rd_en, m_busy);
    check("R9 oam_we", oam_we, m_busy);
    if (m_busy != 0) begin
      check("R8 rd_addr", rd_addr, m_page * 256 + m_idx);
      check("R8 oam_addr", oam_addr, 16'hFE00 + m_idx);
      check("R8 oam_wdata", oam_wdata, mem_model(m_page * 256 + m_idx));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    if (busy) busy_run++;
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    step();
    we = 1'b0;
  endtask

  task automatic rd(input int a);
    we = 1'b0; addr = 4'(a);
    step();
  endtask

  initial begin
    for (int k = 0; k < 10; k++) m_reg[k] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all();
    check("R1 tile_base at reset", tile_base, 16'h0800);
    check("R1 pal_bg at reset", pbg, 32'hFFFFFFFF);
    rst_n = 1'b1;
    rd(0);

    // R2 R3 R4: control patterns
    wr(0, 8'hFF); wr(0, 8'h00); wr(0, 8'h96); wr(0, 8'h09); wr(0, 8'h10);
    // R5: scroll and compare
    wr(2, 8'h3C); wr(3, 8'hA5); wr(5, 8'h90);
    // R7: plain storage and readback
    wr(1, 8'h77); wr(4, 8'hC3);
    for (int k = 0; k < 16; k++) rd(k);
    // R7: out-of-window writes ignored
    for (int k = 10; k < 16; k++) wr(k, 8'hEE);
    for (int k = 0; k < 16; k++) rd(k);
    // R6: palette patterns
    wr(7, 8'hE4); wr(8, 8'h1B); wr(9, 8'hFF);
    wr(7, 8'h00); wr(8, 8'h9C);
    check("R6 spr0 slot1 from 0x9C", ps0[15:8], 8'd0);

    // R8 R9: full transfer, busy counted
    busy_run = 0;
    wr(6, 8'hC0);
    for (int k = 0; k < 170; k++) rd(6);
    check("R9 busy cycles", busy_run, 160);
    check("R7 dma reg readback", rdata, 8'hC0);

    // R10: restart mid-transfer, other writes do not disturb
    busy_run = 0;
    wr(6, 8'h12);
    for (int k = 0; k < 40; k++) rd(k % 16);
    wr(2, 8'h55); wr(0, 8'h83);
    wr(6, 8'h34);
    check("R10 restart index", oam_addr, 16'hFE00);
    for (int k = 0; k < 170; k++) rd(6);
    check("R10 total busy cycles", busy_run, 43 + 160);

    // R8: trigger on the final cycle of a run
    busy_run = 0;
    wr(6, 8'h80);
    for (int k = 0; k < 159; k++) rd(0);
    wr(6, 8'h81);
    for (int k = 0; k < 165; k++) rd(0);
    check("R10 back-to-back busy cycles", busy_run, 320);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule